// File: doc/BRIEF.md
# Interrupt Status, Enable and Clear Unit

This unit collects the interrupt conditions of a serial bus controller into a single status word. Some positions are sticky event flags. A one-cycle pulse from the bus engine sets them, and they stay set until software writes a one to the same position of a separate clear register. The other positions are level flags, such as FIFO occupancy and bus activity. They mirror their source in the same cycle and cannot be cleared.

An enable register selects which status bits may raise the interrupt. The interrupt line is high whenever any enabled status bit is set. A priority output gives the index of the highest pending bit. Error conditions sit at high positions, so they are reported before data-flow conditions. Software reaches all three registers through a simple read/write port. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: A pulse on `ev_pulse` at a sticky position (6 stop-side addressed, 7 stop, 8 arbitration lost, 10 NACK, 11 repeated start; mask 0x0DC0) sets that status bit at the next edge. The bit then stays set without further pulses.
- R2: A write to address 2 clears the sticky status bits whose `reg_wdata` bit is 1. The other sticky bits keep their value.
- R3: Level positions (0–4, 9, 12, 13, 14; mask 0x721F) read the `lvl_in` bit of the same cycle. A write to the clear register has no effect on them.
- R4: When an event pulse and a clear write hit the same sticky bit in one cycle, the bit ends up set.
- R5: Address 1 is the enable register. Only positions 0–4, 6, 7, 8, 10, 11, 12 and 14 (mask 0x5DDF) are writable, and the other bits read 0.
- R6: `irq` is high exactly when status AND enable is non-zero.
- R7: After a write of zero to the enable register, `irq` is low from the next cycle on, whatever the status.
- R8: `pend_valid` equals `irq`. When it is set, `pend_idx` is the highest bit position set in status AND enable.
- R9: After reset, all sticky bits and the enable register are 0 and `irq` is low.
- R10: Status bits 5 and 15 read 0. Event pulses at non-sticky positions are ignored. Address 2 and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 16 | One-cycle event pulses, one per status position |
| lvl_in | input | 16 | Level sources, one per status position |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 clear |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| pend_valid | output | 1 | At least one pending bit |
| pend_idx | output | 4 | Index of the highest pending bit |

## Verification
A sticky bit that is lost, stuck or wrongly cleared shows up in the status read and in `pend_idx` in the cycle after the faulty edge. It remains visible until the next clear, so a model comparison in every cycle detects it at once. A bad enable bit changes `irq` and the priority index only while the matching status bit is set. For that reason the stimulus keeps status bits set across many cycles, and it also reads the enable register back directly.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int W = 16,
  parameter logic [W-1:0] STICKY_MASK = 16'h0DC0,
  parameter logic [W-1:0] LEVEL_MASK  = 16'h721F,
  parameter logic [W-1:0] EN_MASK     = 16'h5DDF,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     ev_pulse,
  input  logic [W-1:0]     lvl_in,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic             irq,
  output logic             pend_valid,
  output logic [IDX_W-1:0] pend_idx
);
  localparam logic [1:0] A_STA = 2'd0;
  localparam logic [1:0] A_EN  = 2'd1;
  localparam logic [1:0] A_CLR = 2'd2;

  logic [W-1:0] sticky_q, en_q, status, pending, clr_mask;

  assign clr_mask = (reg_wr && reg_addr == A_CLR) ? (reg_wdata & STICKY_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      en_q     <= '0;
    end else begin
      sticky_q <= (sticky_q & ~clr_mask) | (ev_pulse & STICKY_MASK);
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata & EN_MASK;
    end
  end

  assign status  = sticky_q | (lvl_in & LEVEL_MASK);
  assign pending = status & en_q;
  assign irq     = |pending;
  assign pend_valid = irq;

  always_comb begin
    pend_idx = '0;
    for (int i = 0; i < W; i++)
      if (pending[i]) pend_idx = IDX_W'(i);
  end

  always_comb begin
    case (reg_addr)
      A_STA:   reg_rdata = status;
      A_EN:    reg_rdata = en_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module irq_status_unit_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] STICKY_MASK = 16'h0DC0,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     ev_pulse,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [W-1:0]     reg_wdata,
  input logic [W-1:0]     reg_rdata,
  input logic             irq,
  input logic             pend_valid,
  input logic [IDX_W-1:0] pend_idx,
  input logic [W-1:0]     sticky_q
);
  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sticky_q & $past(ev_pulse & STICKY_MASK)) == $past(ev_pulse & STICKY_MASK)));

  p_no_spurious_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sticky_q & ~$past(sticky_q) & ~$past(ev_pulse)) == '0));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sticky_q & $past((reg_wr && reg_addr == 2'd2) ?
                        (reg_wdata & ~ev_pulse) : '0)) == '0));

  p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && reg_wr && reg_addr == 2'd1 && reg_wdata == '0) |-> !irq);

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid == irq) && (!pend_valid || reg_addr != 2'd0 || reg_rdata[pend_idx]));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1]) |-> (reg_rdata == '0));
endmodule

bind irq_status_unit irq_status_unit_chk #(.W(W), .STICKY_MASK(STICKY_MASK), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .pend_valid(pend_valid),
  .pend_idx(pend_idx), .sticky_q(sticky_q)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int PERIOD = 10;
  localparam logic [15:0] STK = 16'h0DC0;
  localparam logic [15:0] LVL = 16'h721F;
  localparam logic [15:0] ENM = 16'h5DDF;

  logic clk = 0, rst_n = 0, reg_wr = 0, irq, pend_valid;
  logic [15:0] ev_pulse = 0, lvl_in = 0, reg_wdata = 0, reg_rdata;
  logic [1:0] reg_addr = 0;
  logic [3:0] pend_idx;

  int checks = 0, fails = 0;
  logic [15:0] m_stk = 0, m_en = 0;

  irq_status_unit uut (.clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .lvl_in(lvl_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .pend_valid(pend_valid), .pend_idx(pend_idx));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_status(logic [15:0] s, logic [15:0] l);
    return s | (l & LVL);
  endfunction

  function automatic int exp_idx(logic [15:0] p);
    for (int i = 15; i >= 0; i--) if (p[i]) return i;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic [15:0] ev, logic [15:0] lv, logic wr, logic [1:0] a, logic [15:0] wd);
    logic [15:0] st, pend;
    @(negedge clk);
    ev_pulse = ev; lvl_in = lv; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    st = exp_status(m_stk, lv);
    pend = st & m_en;
    chk("R6 irq", irq, |pend);
    chk("R8 valid", pend_valid, |pend);
    if (|pend) chk("R8 idx", pend_idx, exp_idx(pend));
    case (a)
      2'd0: chk("R1/R3 status read", reg_rdata, st);
      2'd1: chk("R5 enable read", reg_rdata, m_en);
      default: chk("R10 clear read", reg_rdata, 0);
    endcase
    @(posedge clk);
    m_stk = (m_stk & ~((wr && a == 2'd2) ? (wd & STK) : 16'h0)) | (ev & STK);
    if (wr && a == 2'd1) m_en = wd & ENM;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R9 status after reset", reg_rdata, 0);
    chk("R9 irq after reset", irq, 0);
    reg_addr = 1; #1;
    chk("R9 enable after reset", reg_rdata, 0);

    cycle(16'h0, 16'h0, 1, 2'd1, 16'hFFFF);
    @(negedge clk); reg_wr = 0; reg_addr = 1; #1;
    chk("R5 writable enable bits", reg_rdata, 32'h5DDF);

    cycle(16'h0400, 16'h0, 0, 2'd0, 0);
    cycle(16'h0, 16'h0, 0, 2'd0, 0);
    cycle(16'h0, 16'h0, 0, 2'd0, 0);
    @(negedge clk); reg_addr = 0; #1;
    chk("R1 NACK bit held", reg_rdata[10], 1);

    cycle(16'h0, 16'h0004, 0, 2'd0, 0);
    @(negedge clk); lvl_in = 16'h0004; reg_addr = 0; #1;
    chk("R8 error wins priority", pend_idx, 10);

    cycle(16'h0400, 16'h0, 1, 2'd2, 16'h0400);
    @(negedge clk); lvl_in = 0; reg_addr = 0; #1;
    chk("R4 set beats clear", reg_rdata[10], 1);

    cycle(16'h0100, 16'h0, 0, 2'd0, 0);
    cycle(16'h0, 16'h0, 1, 2'd2, 16'h0400);
    @(negedge clk); reg_addr = 0; #1;
    chk("R2 cleared bit", reg_rdata[10], 0);
    chk("R2 other sticky kept", reg_rdata[8], 1);

    cycle(16'h0, 16'h1001, 1, 2'd2, 16'hFFFF);
    @(negedge clk); lvl_in = 16'h1001; reg_addr = 0; #1;
    chk("R3 level bits not cleared", reg_rdata, 32'h1001);

    cycle(16'h8021, 16'h8020, 0, 2'd0, 0);
    @(negedge clk); lvl_in = 0; reg_addr = 0; #1;
    chk("R10 non-sticky pulses ignored", reg_rdata, 0);

    cycle(16'h0080, 16'h0, 0, 2'd0, 0);
    cycle(16'h0, 16'h4000, 1, 2'd1, 16'h0);
    @(negedge clk); lvl_in = 16'h4000; reg_addr = 0; #1;
    chk("R7 masked after zero enable", irq, 0);

    cycle(16'h0, 16'h0, 1, 2'd1, 16'hFFFF);
    for (int n = 0; n < 600; n++) begin
      logic [15:0] ev, lv, wd;
      logic wr;
      logic [1:0] a;
      ev = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      lv = 16'($urandom);
      wr = ($urandom % 3 == 0);
      a  = 2'($urandom);
      wd = 16'($urandom);
      cycle(ev, lv, wr, a, wd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule